// File: doc/BRIEF.md
# Double-Buffered Divider Configuration Loader

This block holds the divide settings of a frequency synthesizer: a 9-bit main divide value, a 6-bit reference divide value, a 4-bit swallow count and a prescaler-enable flag. Software fills a 20-bit primary register in one of two ways. The first is a byte-wide parallel bus with one write strobe per byte section. The second is a serial data/clock pair that shifts the word in most significant bit first. A transfer strobe copies the primary register into a secondary register.

A select input chooses which of the two registers drives the divider outputs. The next channel can therefore be staged in one register while the other is live, and a single select toggle hops between them. A separate 8-bit enhancement register loads over the same parallel or serial paths. Its bits appear at the output only while an active-low enable is held low.

All strobes, the serial pins and the static control pins are brought into the system clock domain and edge-detected. The whole block runs on one clock. Every output is registered.

Top module: `synth_cfg_loader`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is zero.
- R2: With `mode_b` low and `mode_s` low (parallel mode), a rising edge on `sec_wr[k]` loads `data` into section k of the primary word. Section 0 is word bits 7:0, section 1 is bits 15:8, and section 2 is bits 19:16 taken from `data[3:0]`. The word layout is M = bits 19:11, R = bits 10:5, A = bits 4:1 and prescaler enable = bit 0.
- R3: In parallel mode, a rising edge on `hop_wr` copies the primary word into the secondary word.
- R4: With `mode_b` low and `mode_s` high (serial mode), each rising `ser_clk` edge shifts `ser_data` into bit 0 of the primary word while both `enh_wr` and `ser_wr` are low. After 20 edges, the first bit sent sits in bit 19.
- R5: In serial mode, a rising edge on either `ser_wr` or `hop_wr` copies the primary word into the secondary word.
- R6: With `fsel` high the outputs show the primary word; with `fsel` low they show the secondary word. Every output is registered, so while `fsel` toggles each sampled output is one complete stored word.
- R7: In parallel mode, a rising edge on `enh_wr` loads `data` into the enhancement register.
- R8: In serial mode, while `enh_wr` is high and `ser_wr` is low, each rising `ser_clk` edge shifts `ser_data` into bit 0 of the enhancement register. The primary word is left unchanged.
- R9: While `enh_en_n` is high, `enh_out` is zero; while it is low, `enh_out` shows the enhancement register.
- R10: While `mode_b` is high, every write, shift and transfer is ignored.
- R11: The secondary word changes only on a transfer. Section writes and shifts alone leave it unchanged.
- R12: A change on any input is reflected at the outputs no more than four clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_b | input | 1 | Mode pin; must be low for any loading |
| mode_s | input | 1 | Mode pin; low selects parallel, high selects serial |
| data | input | 8 | Parallel data bus |
| sec_wr | input | 3 | Per-section parallel write strobes |
| hop_wr | input | 1 | Primary-to-secondary transfer strobe |
| enh_wr | input | 1 | Enhancement write strobe (parallel) / steering level (serial) |
| ser_wr | input | 1 | Serial transfer strobe |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data in |
| fsel | input | 1 | High selects primary, low selects secondary |
| enh_en_n | input | 1 | Active-low enhancement output enable |
| m_out | output | 9 | Selected main divide value |
| a_out | output | 4 | Selected swallow count |
| r_out | output | 6 | Selected reference divide value |
| pre_en_out | output | 1 | Selected prescaler enable |
| enh_out | output | 8 | Gated enhancement bits |

## Verification
The bench builds the block with the default two-stage synchronizer and the package field widths: 9, 6 and 4 bits plus one flag, in a 20-bit word. With those values the three parallel sections line up exactly with the serial word, and a partial section (the top four bits) is exercised. The four-cycle input-to-output latency is short enough that every pattern can be held and sampled after a fixed eight-cycle settle window. The two stored words are kept different on every field, so that a per-cycle check during select toggles catches any mixed word.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int M_W    = 9;
    localparam int R_W    = 6;
    localparam int A_W    = 4;
    localparam int WORD_W = M_W + R_W + A_W + 1;
    localparam int BYTE_W = 8;
    localparam int ENH_W  = 8;
    localparam int NSEC   = (WORD_W + BYTE_W - 1) / BYTE_W;

    // Field order inside the packed struct matches the shifted word, MSB first.
    typedef struct packed {
        logic [M_W-1:0] m;
        logic [R_W-1:0] r;
        logic [A_W-1:0] a;
        logic           pre_en;
    } div_cfg_t;

    typedef enum logic [1:0] {
        IF_PAR = 2'd0,
        IF_SER = 2'd1,
        IF_OFF = 2'd2
    } if_mode_e;

    function automatic if_mode_e decode_mode(input logic mb, input logic ms);
        if (mb)      return IF_OFF;
        else if (ms) return IF_SER;
        else         return IF_PAR;
    endfunction

    // Overwrite byte section idx of the word; bits past the word end are dropped.
    function automatic logic [WORD_W-1:0] put_section(
        input logic [WORD_W-1:0] w,
        input int                idx,
        input logic [BYTE_W-1:0] b
    );
        logic [WORD_W-1:0] res;
        res = w;
        for (int i = 0; i < WORD_W; i++) begin
            if ((i / BYTE_W) == idx)
                res[i] = b[i - idx * BYTE_W];
        end
        return res;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [STAGES-1:0][W-1:0] pipe;
    logic [W-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
            prev <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++)
                pipe[s] <= pipe[s-1];
            prev <= pipe[STAGES-1];
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~prev;
endmodule

// File: rtl/cfg_primary.sv
module cfg_primary
    import synth_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  if_mode_e             mode,
    input  logic [NSEC-1:0]      sec_rise,
    input  logic                 enh_rise,
    input  logic                 enh_lvl,
    input  logic                 swr_lvl,
    input  logic                 sclk_rise,
    input  logic                 sdata,
    input  logic [BYTE_W-1:0]    data,
    output logic [WORD_W-1:0]    prim_w,
    output logic [ENH_W-1:0]     enh_q
);
    logic [WORD_W-1:0] prim_nxt;
    logic [ENH_W-1:0]  enh_nxt;

    always_comb begin
        prim_nxt = prim_w;
        enh_nxt  = enh_q;
        if (mode == IF_PAR) begin
            for (int k = 0; k < NSEC; k++) begin
                if (sec_rise[k])
                    prim_nxt = put_section(prim_nxt, k, data);
            end
            if (enh_rise)
                enh_nxt = data[ENH_W-1:0];
        end else if (mode == IF_SER && sclk_rise && !swr_lvl) begin
            if (enh_lvl)
                enh_nxt = {enh_q[ENH_W-2:0], sdata};
            else
                prim_nxt = {prim_w[WORD_W-2:0], sdata};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_w <= '0;
            enh_q  <= '0;
        end else begin
            prim_w <= prim_nxt;
            enh_q  <= enh_nxt;
        end
    end
endmodule

// File: rtl/cfg_select.sv
module cfg_select
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer,
    input  logic              fsel,
    input  logic              enh_off,
    input  logic [WORD_W-1:0] prim_w,
    input  logic [ENH_W-1:0]  enh_q,
    output logic [WORD_W-1:0] sec_w,
    output div_cfg_t          cfg_q,
    output logic [ENH_W-1:0]  enh_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sec_w <= '0;
            cfg_q <= '0;
            enh_o <= '0;
        end else begin
            if (xfer)
                sec_w <= prim_w;
            cfg_q <= div_cfg_t'(fsel ? prim_w : sec_w);
            enh_o <= enh_off ? '0 : enh_q;
        end
    end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_b,
    input  logic              mode_s,
    input  logic [BYTE_W-1:0] data,
    input  logic [NSEC-1:0]   sec_wr,
    input  logic              hop_wr,
    input  logic              enh_wr,
    input  logic              ser_wr,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              fsel,
    input  logic              enh_en_n,
    output logic [M_W-1:0]    m_out,
    output logic [A_W-1:0]    a_out,
    output logic [R_W-1:0]    r_out,
    output logic              pre_en_out,
    output logic [ENH_W-1:0]  enh_out
);
    localparam int I_HOP  = NSEC;
    localparam int I_ENH  = NSEC + 1;
    localparam int I_SWR  = NSEC + 2;
    localparam int I_SCLK = NSEC + 3;
    localparam int I_SDAT = NSEC + 4;
    localparam int I_FSEL = NSEC + 5;
    localparam int I_MB   = NSEC + 6;
    localparam int I_MS   = NSEC + 7;
    localparam int I_ENN  = NSEC + 8;
    localparam int CTL_W  = NSEC + 9;

    logic [CTL_W-1:0]  ctl_raw, ctl_lvl, ctl_rise;
    logic [WORD_W-1:0] prim_w, sec_w;
    logic [ENH_W-1:0]  enh_q;
    div_cfg_t          cfg_q;
    if_mode_e          mode;
    logic              xfer;

    assign ctl_raw = {enh_en_n, mode_s, mode_b, fsel, ser_data, ser_clk,
                      ser_wr, enh_wr, hop_wr, sec_wr};

    cfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    (ctl_raw),
        .lvl  (ctl_lvl),
        .rise (ctl_rise)
    );

    assign mode = decode_mode(ctl_lvl[I_MB], ctl_lvl[I_MS]);
    assign xfer = ((mode == IF_PAR) && ctl_rise[I_HOP]) ||
                  ((mode == IF_SER) && (ctl_rise[I_HOP] || ctl_rise[I_SWR]));

    cfg_primary u_prim (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .sec_rise  (ctl_rise[NSEC-1:0]),
        .enh_rise  (ctl_rise[I_ENH]),
        .enh_lvl   (ctl_lvl[I_ENH]),
        .swr_lvl   (ctl_lvl[I_SWR]),
        .sclk_rise (ctl_rise[I_SCLK]),
        .sdata     (ctl_lvl[I_SDAT]),
        .data      (data),
        .prim_w    (prim_w),
        .enh_q     (enh_q)
    );

    cfg_select u_sel (
        .clk     (clk),
        .rst     (rst),
        .xfer    (xfer),
        .fsel    (ctl_lvl[I_FSEL]),
        .enh_off (ctl_lvl[I_ENN]),
        .prim_w  (prim_w),
        .enh_q   (enh_q),
        .sec_w   (sec_w),
        .cfg_q   (cfg_q),
        .enh_o   (enh_out)
    );

    assign m_out      = cfg_q.m;
    assign a_out      = cfg_q.a;
    assign r_out      = cfg_q.r;
    assign pre_en_out = cfg_q.pre_en;
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk
    import synth_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] prim_w,
    input logic [WORD_W-1:0] sec_w,
    input logic [ENH_W-1:0]  enh_q,
    input logic              fsel_s,
    input logic              mb_s,
    input logic              ms_s,
    input logic              enh_s,
    input logic              swr_s,
    input logic              enn_s,
    input logic              hop_r,
    input logic              swr_r,
    input logic [M_W-1:0]    m_out,
    input logic [A_W-1:0]    a_out,
    input logic [R_W-1:0]    r_out,
    input logic              pre_en_out,
    input logic [ENH_W-1:0]  enh_out
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (m_out == '0 && a_out == '0 && r_out == '0 && !pre_en_out && enh_out == '0));

    p_glitch_free_r6: assert property (@(posedge clk) disable iff (rst)
        ($stable(prim_w) && $stable(sec_w) && $stable(fsel_s))
        |=> $stable({m_out, a_out, r_out, pre_en_out}));

    p_enh_primary_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (!mb_s && ms_s && enh_s && !swr_s) |=> $stable(prim_w));

    p_enh_gated_r9: assert property (@(posedge clk) disable iff (rst)
        enn_s |=> (enh_out == '0));

    p_off_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        mb_s |=> ($stable(prim_w) && $stable(sec_w) && $stable(enh_q)));

    p_sec_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(hop_r || swr_r) |=> $stable(sec_w));
endmodule

bind synth_cfg_loader synth_cfg_loader_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .prim_w     (prim_w),
    .sec_w      (sec_w),
    .enh_q      (enh_q),
    .fsel_s     (ctl_lvl[I_FSEL]),
    .mb_s       (ctl_lvl[I_MB]),
    .ms_s       (ctl_lvl[I_MS]),
    .enh_s      (ctl_lvl[I_ENH]),
    .swr_s      (ctl_lvl[I_SWR]),
    .enn_s      (ctl_lvl[I_ENN]),
    .hop_r      (ctl_rise[I_HOP]),
    .swr_r      (ctl_rise[I_SWR]),
    .m_out      (m_out),
    .a_out      (a_out),
    .r_out      (r_out),
    .pre_en_out (pre_en_out),
    .enh_out    (enh_out)
);

// File: tb/synth_cfg_loader_test.sv
module synth_cfg_loader_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_b = 1'b0, mode_s = 1'b0;
    logic [7:0] data = '0;
    logic [2:0] sec_wr = '0;
    logic       hop_wr = 1'b0, enh_wr = 1'b0, ser_wr = 1'b0;
    logic       ser_clk = 1'b0, ser_data = 1'b0;
    logic       fsel = 1'b0, enh_en_n = 1'b1;
    logic [8:0] m_out;
    logic [3:0] a_out;
    logic [5:0] r_out;
    logic       pre_en_out;
    logic [7:0] enh_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    synth_cfg_loader uut (
        .clk(clk), .rst(rst), .mode_b(mode_b), .mode_s(mode_s), .data(data),
        .sec_wr(sec_wr), .hop_wr(hop_wr), .enh_wr(enh_wr), .ser_wr(ser_wr),
        .ser_clk(ser_clk), .ser_data(ser_data), .fsel(fsel), .enh_en_n(enh_en_n),
        .m_out(m_out), .a_out(a_out), .r_out(r_out), .pre_en_out(pre_en_out),
        .enh_out(enh_out)
    );

    typedef struct {
        logic [19:0] w;
        logic [7:0]  e;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Output word rebuilt in the requirement layout: M 19:11, R 10:5, A 4:1, pre 0.
    function automatic logic [19:0] out_word();
        return {m_out, r_out, a_out, pre_en_out};
    endfunction

    // Monitor: waits past the R12 latency, then compares and retires the item.
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            repeat (8) @(posedge clk);
            #1;
            checks++;
            if (out_word() !== exp_q[0].w || enh_out !== exp_q[0].e) begin
                fails++;
                $display("FAIL %s: word=%h enh=%h expected word=%h enh=%h",
                         exp_q[0].tag, out_word(), enh_out, exp_q[0].w, exp_q[0].e);
            end
            void'(exp_q.pop_front());
        end
    end

    task automatic expect_out(input logic [19:0] w, input logic [7:0] e, input string tag);
        exp_q.push_back('{w, e, tag});
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0..2 section strobes, 3 hop, 4 enh, 5 serial write
    task automatic strobe(input int which);
        case (which)
            0, 1, 2: sec_wr[which] = 1'b1;
            3: hop_wr = 1'b1;
            4: enh_wr = 1'b1;
            default: ser_wr = 1'b1;
        endcase
        hold(4);
        sec_wr = '0; hop_wr = 1'b0; enh_wr = 1'b0; ser_wr = 1'b0;
        hold(4);
    endtask

    task automatic par_write(input int sec, input logic [7:0] b);
        data = b;
        hold(1);
        strobe(sec);
    endtask

    task automatic par_word(input logic [19:0] w);
        par_write(0, w[7:0]);
        par_write(1, w[15:8]);
        par_write(2, {4'h0, w[19:16]});
    endtask

    task automatic ser_bits(input logic [19:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            hold(4);
            ser_clk = 1'b1;
            hold(4);
            ser_clk = 1'b0;
        end
        hold(4);
    endtask

    // R6: every cycle during a select toggle must show one whole stored word.
    task automatic toggle_watch(input logic new_sel, input logic [19:0] wa, input logic [19:0] wb);
        fsel = new_sel;
        for (int c = 0; c < 8; c++) begin
            @(posedge clk);
            #1;
            checks++;
            if (out_word() !== wa && out_word() !== wb) begin
                fails++;
                $display("FAIL R6 toggle cycle %0d: word=%h expected %h or %h",
                         c, out_word(), wa, wb);
            end
        end
        @(negedge clk);
    endtask

    localparam logic [19:0] W1 = {9'h155, 6'h2A, 4'h9, 1'b1};
    localparam logic [19:0] W2 = {9'h0C3, 6'h11, 4'h6, 1'b0};
    localparam logic [19:0] W3 = {9'h001, 6'h00, 4'h3, 1'b1};
    localparam logic [19:0] W4 = {9'h0AA, 6'h15, 4'hA, 1'b0};
    localparam logic [19:0] W1B = {W1[19:8], 8'h3C};

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        hold(3);
        checks++;
        if (out_word() !== 20'h0 || enh_out !== 8'h0) begin
            fails++;
            $display("FAIL R1 in reset: word=%h enh=%h expected 0 0", out_word(), enh_out);
        end
        rst = 1'b0;
        expect_out(20'h0, 8'h0, "R1 after reset");

        // Parallel mode
        par_word(W1);
        fsel = 1'b1;
        expect_out(W1, 8'h0, "R2 sections to primary");
        fsel = 1'b0;
        expect_out(20'h0, 8'h0, "R11 secondary untouched before hop");
        strobe(3);
        expect_out(W1, 8'h0, "R3 hop transfer");
        par_write(0, 8'h3C);
        expect_out(W1, 8'h0, "R11 section write keeps secondary");
        fsel = 1'b1;
        expect_out(W1B, 8'h0, "R2 low section rewritten");
        par_write(4, 8'hA5);
        expect_out(W1B, 8'h0, "R9 enhancement gated off");
        enh_en_n = 1'b0;
        expect_out(W1B, 8'hA5, "R7 parallel enhancement write");

        // Serial mode
        mode_s = 1'b1;
        hold(4);
        ser_bits(W2, 20);
        expect_out(W2, 8'hA5, "R4 serial shift MSB first");
        fsel = 1'b0;
        expect_out(W1, 8'hA5, "R11 shift keeps secondary");
        strobe(5);
        expect_out(W2, 8'hA5, "R5 serial-write transfer");
        fsel = 1'b1;
        enh_wr = 1'b1;
        hold(4);
        ser_bits({12'h0, 8'h3C}, 8);
        enh_wr = 1'b0;
        hold(4);
        expect_out(W2, 8'h3C, "R8 serial enhancement shift, primary kept");
        ser_bits(W3, 20);
        strobe(3);
        fsel = 1'b0;
        expect_out(W3, 8'h3C, "R5 hop transfer in serial mode");
        ser_bits(W4, 20);
        fsel = 1'b0;
        expect_out(W3, 8'h3C, "R6 secondary selected");

        toggle_watch(1'b1, W3, W4);
        expect_out(W4, 8'h3C, "R6 primary after toggle");
        toggle_watch(1'b0, W3, W4);
        expect_out(W3, 8'h3C, "R6 secondary after toggle");

        // Loading disabled
        mode_b = 1'b1;
        mode_s = 1'b0;
        hold(4);
        par_write(0, 8'hFF);
        par_write(4, 8'h11);
        strobe(3);
        fsel = 1'b1;
        expect_out(W4, 8'h3C, "R10 writes ignored (primary)");
        fsel = 1'b0;
        expect_out(W3, 8'h3C, "R10 hop ignored (secondary)");
        mode_s = 1'b1;
        ser_bits(20'hFFFFF, 20);
        strobe(5);
        fsel = 1'b1;
        expect_out(W4, 8'h3C, "R10 serial ignored");

        // R12: one change must appear within four cycles
        fsel = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        checks++;
        if (out_word() !== W3) begin
            fails++;
            $display("FAIL R12 latency: word=%h expected %h", out_word(), W3);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule